// File: doc/BRIEF.md
# Inverse Quantizer with Run-Level Event Coder

This block walks one macroblock of quantized transform coefficients (six 8×8 blocks) held in an external synchronous-read buffer. It makes a single read pass in zigzag order within each block. Every coefficient read feeds two independent output paths at once. The first path reconstructs the coefficient value and writes it back in raster position into one of four coefficient buffers. The second path turns the same coefficient stream into packed (last, run, level) events and writes them into one of two event buffers.

A controller fires a macroblock with a one-cycle start pulse. The block then runs on its own at one coefficient per cycle. It inserts one spare cycle after each 8×8 block so that the held-back final event of that block can be written. At the end it raises a done flag, which stays high until the next accepted start. The flag can be polled or wired to an interrupt. The coefficient buffer index advances in rotation over four buffers and the event buffer index alternates between two, both once per macroblock. A downstream stage can therefore work on the previous results while the next macroblock is processed.

Top module: `iq_rle_engine`

## Requirements
- R1: After reset, and whenever `done_o` is high, the block performs no writes. `done_o` resets to 0 and nothing happens until `start_i` is accepted.
- R2: A non-zero level L at quantizer step Q (1..31) reconstructs with magnitude Q·(2|L|+1), reduced by 1 when Q is even. The sign of L is restored, and the result is clamped to the 12-bit two's-complement range -2048..2047.
- R3: A zero level reconstructs to 0 and produces no event, so no event ever carries a zero level field.
- R4: The run field of an event counts the zero levels that precede that coefficient in zigzag order, back to the previous non-zero coefficient of the same 8×8 block or to the block start.
- R5: The final non-zero coefficient of each 8×8 block produces its event with the last flag set, and every other event has it clear. A block with only zero levels produces no events.
- R6: An event word is 15 bits: bit 14 is the last flag, bits 13:8 the run, and bits 7:0 the level in two's complement, clamped to -128..127.
- R7: Coefficient n (0..63) of block b is read in zigzag order. The zigzag order starts at (0,0) and moves along the anti-diagonals: on even diagonals the row decreases, on odd diagonals the row increases. Each coefficient is read exactly once, and its reconstruction is written at address b·64 + row·8 + col.
- R8: The coefficient buffer index (`coef_buf_o`) is 0 for the first macroblock after reset and advances 0,1,2,3,0 per macroblock. The event buffer index (`ev_buf_o`) is 0 first and then alternates. All writes of a macroblock use the same index.
- R9: The event addresses of a macroblock run consecutively from 0.
- R10: `done_o` rises only after every write of the macroblock and holds until the next start. A start pulse that arrives while a macroblock is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| qp_i | input | 5 | Quantizer step, sampled at start |
| done_o | output | 1 | Macroblock finished; held until next start |
| in_addr_o | output | 9 | Read address into the quantized-level buffer |
| in_data_i | input | 11 | Level read from the buffer, one cycle after the address |
| coef_we_o | output | 1 | Reconstructed coefficient write strobe |
| coef_buf_o | output | 2 | Coefficient buffer index |
| coef_addr_o | output | 9 | Raster coefficient address within the macroblock |
| coef_data_o | output | 12 | Reconstructed coefficient |
| ev_we_o | output | 1 | Event write strobe |
| ev_buf_o | output | 1 | Event buffer index |
| ev_addr_o | output | 9 | Event address |
| ev_data_o | output | 15 | Packed event word |

## Verification
Some properties are checked by assertions on every cycle. No write occurs while done is high. Event levels are never zero. Event addresses step by one from zero within a macroblock. Consecutive coefficient writes keep the same buffer index. Done holds until start. The reconstruction arithmetic, the zigzag read order, the run counts, the last-flag placement, empty blocks and buffer rotation can only be shown by the bench scenarios. These scenarios compare whole buffers against an independent model over random and hand-built blocks. They include a lone coefficient at zigzag 63, extreme levels at odd and even steps, and a start pulse sent mid-run.

// File: rtl/iq_pkg.sv
package iq_pkg;
  typedef enum logic [0:0] {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_t;

  // per-slot side information that travels with a read through the pipe
  typedef struct packed {
    logic valid;   // slot carries a coefficient
    logic flush;   // spare slot after the end of an 8x8 block
    logic mbend;   // flush slot that closes the macroblock
  } slot_t;
endpackage

// File: rtl/zz_walker.sv
module zz_walker
  import iq_pkg::*;
#(
  parameter int BLK_N  = 8,
  parameter int BLOCKS = 6,
  parameter int AW     = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  output logic          active,
  output slot_t         iss,
  output logic [AW-1:0] iss_addr
);
  localparam int BLK_SZ = BLK_N * BLK_N;
  localparam int RCW    = $clog2(BLK_N);
  localparam int KW     = $clog2(BLK_SZ);
  localparam int BW     = (BLOCKS > 1) ? $clog2(BLOCKS) : 1;

  seq_state_t     state;
  logic [RCW-1:0] row, col;
  logic           dir_up;
  logic [KW-1:0]  k;
  logic [BW-1:0]  blk;
  logic           gap;

  assign active = (state == SEQ_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      row      <= '0;
      col      <= '0;
      dir_up   <= 1'b1;
      k        <= '0;
      blk      <= '0;
      gap      <= 1'b0;
      iss      <= '0;
      iss_addr <= '0;
    end else begin
      iss <= '0;
      case (state)
        SEQ_IDLE: begin
          if (go) begin
            state  <= SEQ_RUN;
            row    <= '0;
            col    <= '0;
            dir_up <= 1'b1;
            k      <= '0;
            blk    <= '0;
            gap    <= 1'b0;
          end
        end
        SEQ_RUN: begin
          if (gap) begin
            iss.flush <= 1'b1;
            gap       <= 1'b0;
            if (blk == BW'(BLOCKS - 1)) begin
              iss.mbend <= 1'b1;
              state     <= SEQ_IDLE;
            end else begin
              blk <= blk + 1'b1;
            end
          end else begin
            iss.valid <= 1'b1;
            iss_addr  <= AW'(blk) * AW'(BLK_SZ) + AW'(row) * AW'(BLK_N) + AW'(col);
            k         <= k + 1'b1;
            if (dir_up) begin
              if (col == RCW'(BLK_N - 1)) begin
                row    <= row + 1'b1;
                dir_up <= 1'b0;
              end else if (row == '0) begin
                col    <= col + 1'b1;
                dir_up <= 1'b0;
              end else begin
                row <= row - 1'b1;
                col <= col + 1'b1;
              end
            end else begin
              if (row == RCW'(BLK_N - 1)) begin
                col    <= col + 1'b1;
                dir_up <= 1'b1;
              end else if (col == '0) begin
                row    <= row + 1'b1;
                dir_up <= 1'b1;
              end else begin
                row <= row + 1'b1;
                col <= col - 1'b1;
              end
            end
            if (k == KW'(BLK_SZ - 1)) begin
              gap    <= 1'b1;
              k      <= '0;
              row    <= '0;
              col    <= '0;
              dir_up <= 1'b1;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iq_dequant.sv
module iq_dequant #(
  parameter int QW  = 11,
  parameter int CW  = 12,
  parameter int QPW = 5,
  parameter int AW  = 9,
  parameter int CBW = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid,
  input  logic [AW-1:0]        addr,
  input  logic signed [QW-1:0] level,
  input  logic [QPW-1:0]       qp,
  input  logic [CBW-1:0]       buf_sel,
  output logic                 we,
  output logic [CBW-1:0]       wbuf,
  output logic [AW-1:0]        waddr,
  output logic [CW-1:0]        wdata
);
  localparam int CMAX = (1 << (CW - 1)) - 1;
  localparam int CMIN = -(1 << (CW - 1));

  logic [CW-1:0] rec;

  always_comb begin
    int li, mag, p;
    li  = int'(level);
    mag = (li < 0) ? -li : li;
    p   = int'(qp) * (2 * mag + 1) - (qp[0] ? 0 : 1);
    if (li < 0) p = -p;
    if (li == 0) p = 0;
    if (p > CMAX) p = CMAX;
    if (p < CMIN) p = CMIN;
    rec = CW'(p);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      we    <= 1'b0;
      wbuf  <= '0;
      waddr <= '0;
      wdata <= '0;
    end else begin
      we <= valid;
      if (valid) begin
        wbuf  <= buf_sel;
        waddr <= addr;
        wdata <= rec;
      end
    end
  end
endmodule

// File: rtl/rl_event.sv
module rl_event #(
  parameter int QW   = 11,
  parameter int RUNW = 6,
  parameter int LVLW = 8,
  parameter int AW   = 9,
  parameter int EBW  = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     valid,
  input  logic signed [QW-1:0]     level,
  input  logic                     flush,
  input  logic                     mbend,
  input  logic [EBW-1:0]           buf_sel,
  output logic                     we,
  output logic [EBW-1:0]           wbuf,
  output logic [AW-1:0]            waddr,
  output logic [RUNW+LVLW:0]       wdata
);
  localparam int LMAX = (1 << (LVLW - 1)) - 1;
  localparam int LMIN = -(1 << (LVLW - 1));

  logic [RUNW-1:0] run_q;
  logic            pend_v;
  logic [RUNW-1:0] pend_run;
  logic [LVLW-1:0] pend_lvl;
  logic [AW-1:0]   addr_q;
  logic [LVLW-1:0] lvl_sat;
  logic            nz;

  always_comb begin
    int li;
    li = int'(level);
    if (li > LMAX) li = LMAX;
    if (li < LMIN) li = LMIN;
    lvl_sat = LVLW'(li);
    nz      = (level != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= '0;
      pend_v   <= 1'b0;
      pend_run <= '0;
      pend_lvl <= '0;
      addr_q   <= '0;
      we       <= 1'b0;
      wbuf     <= '0;
      waddr    <= '0;
      wdata    <= '0;
    end else begin
      we <= 1'b0;
      if (valid) begin
        if (nz) begin
          if (pend_v) begin
            we     <= 1'b1;
            wbuf   <= buf_sel;
            waddr  <= addr_q;
            wdata  <= {1'b0, pend_run, pend_lvl};
            addr_q <= addr_q + 1'b1;
          end
          pend_v   <= 1'b1;
          pend_run <= run_q;
          pend_lvl <= lvl_sat;
          run_q    <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
      if (flush) begin
        if (pend_v) begin
          we     <= 1'b1;
          wbuf   <= buf_sel;
          waddr  <= addr_q;
          wdata  <= {1'b1, pend_run, pend_lvl};
          addr_q <= addr_q + 1'b1;
        end
        pend_v <= 1'b0;
        run_q  <= '0;
        if (mbend) addr_q <= '0;
      end
    end
  end
endmodule

// File: rtl/iq_rle_engine.sv
module iq_rle_engine
  import iq_pkg::*;
#(
  parameter int QW     = 11,
  parameter int CW     = 12,
  parameter int QPW    = 5,
  parameter int LVLW   = 8,
  parameter int BLK_N  = 8,
  parameter int BLOCKS = 6,
  parameter int NCB    = 4,
  parameter int NEB    = 2,
  localparam int BLK_SZ = BLK_N * BLK_N,
  localparam int MB_SZ  = BLOCKS * BLK_SZ,
  localparam int AW     = $clog2(MB_SZ),
  localparam int RUNW   = $clog2(BLK_SZ),
  localparam int EVW    = 1 + RUNW + LVLW,
  localparam int CBW    = $clog2(NCB),
  localparam int EBW    = $clog2(NEB)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [QPW-1:0]       qp_i,
  output logic                 done_o,
  output logic [AW-1:0]        in_addr_o,
  input  logic signed [QW-1:0] in_data_i,
  output logic                 coef_we_o,
  output logic [CBW-1:0]       coef_buf_o,
  output logic [AW-1:0]        coef_addr_o,
  output logic [CW-1:0]        coef_data_o,
  output logic                 ev_we_o,
  output logic [EBW-1:0]       ev_buf_o,
  output logic [AW-1:0]        ev_addr_o,
  output logic [EVW-1:0]       ev_data_o
);
  slot_t          iss, s1;
  logic [AW-1:0]  iss_addr, s1_addr;
  logic           seq_active, s2_mbend, accept;
  logic [QPW-1:0] qp_q;
  logic [CBW-1:0] cbuf_q;
  logic [EBW-1:0] ebuf_q;

  assign accept    = start_i && !seq_active && (iss == '0) && (s1 == '0) && !s2_mbend;
  assign in_addr_o = iss_addr;

  zz_walker #(.BLK_N(BLK_N), .BLOCKS(BLOCKS), .AW(AW)) u_walk (
    .clk(clk), .rst(rst), .go(accept), .active(seq_active),
    .iss(iss), .iss_addr(iss_addr)
  );

  // stage 1 aligns slot info with the synchronous read data
  always_ff @(posedge clk) begin
    if (rst) begin
      s1       <= '0;
      s1_addr  <= '0;
      s2_mbend <= 1'b0;
      qp_q     <= '0;
      cbuf_q   <= '0;
      ebuf_q   <= '0;
      done_o   <= 1'b0;
    end else begin
      s1       <= iss;
      s1_addr  <= iss_addr;
      s2_mbend <= s1.mbend;
      if (accept) begin
        qp_q   <= qp_i;
        done_o <= 1'b0;
      end
      if (s2_mbend) done_o <= 1'b1;
      if (s1.mbend) begin
        cbuf_q <= (cbuf_q == CBW'(NCB - 1)) ? '0 : cbuf_q + 1'b1;
        ebuf_q <= (ebuf_q == EBW'(NEB - 1)) ? '0 : ebuf_q + 1'b1;
      end
    end
  end

  iq_dequant #(.QW(QW), .CW(CW), .QPW(QPW), .AW(AW), .CBW(CBW)) u_deq (
    .clk(clk), .rst(rst), .valid(s1.valid), .addr(s1_addr), .level(in_data_i),
    .qp(qp_q), .buf_sel(cbuf_q), .we(coef_we_o), .wbuf(coef_buf_o),
    .waddr(coef_addr_o), .wdata(coef_data_o)
  );

  rl_event #(.QW(QW), .RUNW(RUNW), .LVLW(LVLW), .AW(AW), .EBW(EBW)) u_rle (
    .clk(clk), .rst(rst), .valid(s1.valid), .level(in_data_i),
    .flush(s1.flush), .mbend(s1.mbend), .buf_sel(ebuf_q),
    .we(ev_we_o), .wbuf(ev_buf_o), .waddr(ev_addr_o), .wdata(ev_data_o)
  );
endmodule

// File: rtl/iq_rle_checker.sv
module iq_rle_checker #(
  parameter int AW    = 9,
  parameter int CBW   = 2,
  parameter int EVW   = 15,
  parameter int MB_SZ = 384
) (
  input logic           clk,
  input logic           rst,
  input logic           start_i,
  input logic           done_o,
  input logic           coef_we_o,
  input logic [CBW-1:0] coef_buf_o,
  input logic [AW-1:0]  coef_addr_o,
  input logic           ev_we_o,
  input logic [AW-1:0]  ev_addr_o,
  input logic [EVW-1:0] ev_data_o
);
  logic [AW-1:0] ev_exp;

  always_ff @(posedge clk) begin
    if (rst)          ev_exp <= '0;
    else if (done_o)  ev_exp <= '0;
    else if (ev_we_o) ev_exp <= ev_exp + 1'b1;
  end

  a_r1_quiet_when_done: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!coef_we_o && !ev_we_o));

  a_r3_no_zero_level: assert property (@(posedge clk) disable iff (rst)
    ev_we_o |-> (ev_data_o[7:0] != 8'd0));

  a_r9_event_addr_step: assert property (@(posedge clk) disable iff (rst)
    ev_we_o |-> (ev_addr_o == ev_exp));

  a_r8_coef_buf_steady: assert property (@(posedge clk) disable iff (rst)
    (coef_we_o && $past(coef_we_o)) |-> $stable(coef_buf_o));

  a_r7_coef_addr_range: assert property (@(posedge clk) disable iff (rst)
    coef_we_o |-> (int'(coef_addr_o) < MB_SZ));

  a_r10_done_hold: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> done_o);
endmodule

bind iq_rle_engine iq_rle_checker #(.AW(AW), .CBW(CBW), .EVW(EVW), .MB_SZ(MB_SZ)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .done_o(done_o),
  .coef_we_o(coef_we_o), .coef_buf_o(coef_buf_o), .coef_addr_o(coef_addr_o),
  .ev_we_o(ev_we_o), .ev_addr_o(ev_addr_o), .ev_data_o(ev_data_o)
);

// File: tb/iq_rle_engine_test.sv
module iq_rle_engine_test;
  localparam int MB = 384;

  logic               clk = 0, rst = 1, start_i = 0;
  logic [4:0]         qp_i = 5'd1;
  logic               done_o;
  logic [8:0]         in_addr_o;
  logic signed [10:0] in_data_i;
  logic               coef_we_o, ev_we_o, ev_buf_o;
  logic [1:0]         coef_buf_o;
  logic [8:0]         coef_addr_o, ev_addr_o;
  logic [11:0]        coef_data_o;
  logic [14:0]        ev_data_o;

  iq_rle_engine uut (
    .clk(clk), .rst(rst), .start_i(start_i), .qp_i(qp_i), .done_o(done_o),
    .in_addr_o(in_addr_o), .in_data_i(in_data_i),
    .coef_we_o(coef_we_o), .coef_buf_o(coef_buf_o), .coef_addr_o(coef_addr_o),
    .coef_data_o(coef_data_o), .ev_we_o(ev_we_o), .ev_buf_o(ev_buf_o),
    .ev_addr_o(ev_addr_o), .ev_data_o(ev_data_o)
  );

  always #4 clk = ~clk;

  int mem [MB];
  int zz [64];
  int cap_coef [4][MB];
  int cap_hit [4][MB];
  int cap_ev [2][MB];
  int ev_cnt [2];
  int exp_ev [MB];
  int exp_n;
  int n_checks = 0, n_fail = 0, stray = 0, cycles = 0;
  bit running = 0;

  always @(posedge clk) in_data_i <= 11'(mem[in_addr_o]);
  always @(posedge clk) cycles <= cycles + 1;

  always @(negedge clk) begin
    if (coef_we_o) begin
      cap_coef[coef_buf_o][coef_addr_o] = int'($signed(coef_data_o));
      cap_hit[coef_buf_o][coef_addr_o] += 1;
    end
    if (ev_we_o) begin
      cap_ev[ev_buf_o][ev_addr_o] = int'(ev_data_o);
      ev_cnt[ev_buf_o] += 1;
    end
    if (!running && (coef_we_o || ev_we_o)) stray++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int deq(int l, int q);
    int m, p;
    if (l == 0) return 0;
    m = (l < 0) ? -l : l;
    p = q * (2 * m + 1);
    if (q % 2 == 0) p = p - 1;
    if (l < 0) p = -p;
    if (p > 2047) p = 2047;
    if (p < -2048) p = -2048;
    return p;
  endfunction

  function automatic int pack_ev(int last, int run, int l);
    int s;
    s = (l > 127) ? 127 : ((l < -128) ? -128 : l);
    return (last << 14) | (run << 8) | (s & 8'hFF);
  endfunction

  task automatic build_expected();
    exp_n = 0;
    for (int b = 0; b < 6; b++) begin
      int run = 0;
      int first = exp_n;
      for (int k = 0; k < 64; k++) begin
        int l = mem[b * 64 + zz[k]];
        if (l == 0) run++;
        else begin
          exp_ev[exp_n] = pack_ev(0, run, l);
          exp_n++;
          run = 0;
        end
      end
      if (exp_n > first) exp_ev[exp_n - 1] |= (1 << 14);
    end
  endtask

  function automatic int rnd_lvl(int lim);
    return int'($urandom_range(0, 2 * lim)) - lim;
  endfunction

  task automatic fill(input int mbn);
    for (int b = 0; b < 6; b++) begin
      int kind = (mbn + b) % 6;
      for (int i = 0; i < 64; i++) begin
        int v = 0;
        case (kind)
          0: v = ($urandom_range(0, 3) == 0) ? rnd_lvl(20) : 0;
          1: v = rnd_lvl(1023);
          2: v = 0;
          3: v = 0;
          4: v = ($urandom_range(0, 7) == 0) ? rnd_lvl(300) : 0;
          default: v = ($urandom_range(0, 1) == 0) ? rnd_lvl(4) : 0;
        endcase
        mem[b * 64 + i] = v;
      end
      if (kind == 3) mem[b * 64 + zz[63]] = (mbn % 2 == 0) ? -200 : 1023;
      if (kind == 2 && mbn % 3 == 0) mem[b * 64 + zz[0]] = 1;
      if (kind == 1 && mbn < 4) begin
        mem[b * 64 + zz[0]] = -1024;
        mem[b * 64 + zz[1]] = 1023;
        mem[b * 64 + zz[2]] = 128;
        mem[b * 64 + zz[3]] = -129;
        mem[b * 64 + zz[4]] = 127;
        mem[b * 64 + zz[5]] = -128;
      end
    end
  endtask

  int ref_lat = -1;

  task automatic run_mb(input int mbn, input int q, input bit extra_start);
    int cb = mbn % 4, eb = mbn % 2, t0, lat, wait_n, tot;
    fill(mbn);
    build_expected();
    for (int a = 0; a < MB; a++) cap_hit[cb][a] = 0;
    ev_cnt[0] = 0; ev_cnt[1] = 0;
    @(negedge clk);
    qp_i = 5'(q); start_i = 1; running = 1;
    t0 = cycles;
    @(negedge clk);
    start_i = 0;
    if (extra_start) begin
      repeat (100) @(negedge clk);
      qp_i = 5'(q ^ 3); start_i = 1;
      @(negedge clk);
      start_i = 0;
    end
    wait_n = 0;
    while (!done_o && wait_n < 3000) begin
      @(negedge clk);
      wait_n++;
    end
    check(done_o, "R10 done within watchdog", int'(done_o), 1);
    lat = cycles - t0;
    if (ref_lat < 0) ref_lat = lat;
    else check(lat == ref_lat, "R10 done latency unchanged", lat, ref_lat);
    running = 0;
    repeat (3) @(negedge clk);
    check(done_o, "R10 done held", int'(done_o), 1);
    tot = 0;
    for (int a = 0; a < MB; a++) begin
      int e = deq(mem[a], q);
      check(cap_hit[cb][a] == 1, "R7/R8 one write per address in buffer", cap_hit[cb][a], 1);
      check(cap_coef[cb][a] == e, (mem[a] == 0) ? "R3 zero reconstruction" : "R2 reconstruction",
            cap_coef[cb][a], e);
      tot += cap_hit[cb][a];
    end
    check(ev_cnt[eb] == exp_n, "R5/R8 event count in buffer", ev_cnt[eb], exp_n);
    check(ev_cnt[1 - eb] == 0, "R8 other event buffer untouched", ev_cnt[1 - eb], 0);
    for (int i = 0; i < exp_n; i++)
      check(cap_ev[eb][i] == exp_ev[i], "R4/R5/R6/R9 event word", cap_ev[eb][i], exp_ev[i]);
  endtask

  initial begin
    int k = 0;
    int seed;
    for (int s = 0; s < 15; s++) begin
      if (s % 2 == 0) begin
        for (int r = (s < 7 ? s : 7); r >= (s > 7 ? s - 7 : 0); r--) begin
          zz[k] = r * 8 + (s - r); k++;
        end
      end else begin
        for (int r = (s > 7 ? s - 7 : 0); r <= (s < 7 ? s : 7); r++) begin
          zz[k] = r * 8 + (s - r); k++;
        end
      end
    end
    for (int a = 0; a < MB; a++) mem[a] = 0;
    seed = $urandom(32'h1F2E3D);
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(done_o == 0, "R1 done low after reset", int'(done_o), 0);
    repeat (20) @(negedge clk);
    check(stray == 0, "R1 no writes before start", stray, 0);
    for (int m = 0; m < 30; m++) begin
      int q;
      case (m)
        0: q = 1; 1: q = 2; 2: q = 31; 3: q = 30;
        default: q = int'($urandom_range(1, 31));
      endcase
      run_mb(m, q, m == 5);
      repeat (5) @(negedge clk);
      check(stray == 0, "R1 no writes while done", stray, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_checks++; n_fail++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule